// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A synthesizable model of a single-port synchronous static RAM. It stores words of four byte lanes and reads them through a two-stage registered pipeline. Address, control and write data are captured on the rising clock edge. Every access starts with one of two address strobes: a processor strobe and a controller strobe. A separate sequencer then walks the low two address bits through a four-beat burst each cycle that the advance input is high. Three chip enables of mixed polarity decide whether a starting access selects the array or deselects it.

A read captured at one edge lands in the output register at the next edge, so the data seen in a cycle belongs to the read issued in the previous clock period. Writes are either global, which writes all lanes, or byte-gated, which writes only the lanes that are strobed. They are committed one edge after capture, so a read in the following cycle already returns the new word. The output is a data word plus a valid flag rather than a tristate bus, and an asynchronous output enable forces both to idle. A sleep input freezes the block. Stored contents are kept, but no access is accepted while it is held.

Top module: `sburst_sram`

## Requirements
- R1: An access starts only when a strobe is recognised and csa_n=0, csb=1 and csc_n=0 at that edge. Any other combination makes the start a deselect: nothing is read or written, and rvalid is low two edges later.
- R2: A read captured at edge k drives its word on rdata with rvalid=1 after edge k+1, when out_en_n=0 and sleep is low at edge k+1.
- R3: With wr_all_n=0 an accepted write stores all four lanes, whatever wr_lane_en_n and lane_n are. Lane a is bits 7:0, b is 15:8, c is 23:16 and d is 31:24.
- R4: With wr_all_n=1 and wr_lane_en_n=0, only lanes whose lane_n bit is 0 are written. lane_n[0] is lane a and lane_n[3] is lane d, and lane_n=4'hF changes nothing.
- R5: A write never loads the output register. After the edge that commits it, rvalid=0 and rdata holds its previous value. A read issued in the cycle after the write returns the new data.
- R6: Deselect takes one cycle. A read in flight still appears after the deselecting edge, and rvalid is low after the following edge.
- R7: out_en_n=1 forces rdata to 0 and rvalid to 0 at once, with no clock edge. Returning it to 0 restores the registered output.
- R8: At an edge where sleep=1, no access or write is accepted, any burst in progress ends, and the output register is cleared. rvalid stays low until one edge after the first awake edge, and the memory contents are kept.
- R9: The processor strobe is recognised only when csa_n=0, and it then wins over the controller strobe. A start by the processor strobe is always a read and ignores the write controls. A start by the controller strobe honours them.
- R10: While a burst is active and no strobe is recognised, adv_i=1 steps to the next beat and adv_i=0 repeats the current address. The upper address bits stay fixed. With BURST_LINEAR=0 (the default), beat n uses low bits base XOR n. With BURST_LINEAR=1, it uses (base+n) mod 4.
- R11: With no burst active and no strobe, adv_i and the write controls have no effect: nothing is written and rvalid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| csa_n | input | 1 | Chip enable A, active low; also gates the processor strobe |
| csb | input | 1 | Chip enable B, active high |
| csc_n | input | 1 | Chip enable C, active low |
| as_proc_n | input | 1 | Processor address strobe, active low |
| as_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_i | input | 1 | Burst advance, active high |
| wr_all_n | input | 1 | Global write, active low |
| wr_lane_en_n | input | 1 | Byte-gated write enable, active low |
| lane_n | input | LANES | Per-lane write strobes, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-power hold, active high |
| rdata | output | LANES*LANE_W | Read data from the output register |
| rvalid | output | 1 | High when rdata carries a read result |

## Verification
The functions that can fall in the same cycle are the two address strobes, and equally an access start and a sleep request. The bench asserts both strobes together with the write controls active. It judges the result by a read result that appears one cycle later and by reading the address back, which shows that the processor strobe won and nothing was written. It also raises sleep in the cycle where a pipelined read would surface and asserts a controller write alongside it. The output must go idle at once, and a later read must show the stored word unchanged.

// File: rtl/sburst_pkg.sv
package sburst_pkg;

    // Operation held in the capture stage between the two pipeline edges
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } sb_op_e;

endpackage

// File: rtl/sburst_seq.sv
module sburst_seq #(
    parameter int BURST_W      = 2,
    parameter bit BURST_LINEAR = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               step_i,
    input  logic [BURST_W-1:0] ld_bits_i,
    output logic [BURST_W-1:0] bits_o
);

    typedef struct packed {
        logic [BURST_W-1:0] base;
        logic [BURST_W-1:0] cnt;
    } seq_t;

    seq_t               s_d, s_q;
    logic [BURST_W-1:0] cnt_use;
    logic [BURST_W-1:0] base_use;

    always_comb begin
        s_d      = s_q;
        cnt_use  = s_q.cnt;
        base_use = s_q.base;
        if (load_i) begin
            s_d.base = ld_bits_i;
            s_d.cnt  = '0;
            cnt_use  = '0;
            base_use = ld_bits_i;
        end else if (step_i) begin
            s_d.cnt = s_q.cnt + 1'b1;
            cnt_use = s_d.cnt;
        end
    end

    generate
        if (BURST_LINEAR) begin : g_linear
            assign bits_o = base_use + cnt_use;
        end else begin : g_interleave
            assign bits_o = base_use ^ cnt_use;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/sburst_ctl.sv
module sburst_ctl
    import sburst_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int BURST_W = 2,
    parameter int LANES   = 4,
    parameter int DW      = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      csa_n,
    input  logic                      csb,
    input  logic                      csc_n,
    input  logic                      as_proc_n,
    input  logic                      as_ctrl_n,
    input  logic                      adv_i,
    input  logic                      wr_all_n,
    input  logic                      wr_lane_en_n,
    input  logic [LANES-1:0]          lane_n,
    input  logic [ADDR_W-BURST_W-1:0] addr_hi_i,
    input  logic [DW-1:0]             wdata,
    input  logic                      sleep,
    input  logic [BURST_W-1:0]        seq_bits_i,
    output logic                      seq_load_o,
    output logic                      seq_step_o,
    output sb_op_e                    st_op_o,
    output logic [ADDR_W-1:0]         st_addr_o,
    output logic [LANES-1:0]          st_mask_o,
    output logic [DW-1:0]             st_wdata_o
);

    localparam int HI_W = ADDR_W - BURST_W;

    typedef struct packed {
        logic              act;
        logic [HI_W-1:0]   hi;
        sb_op_e            op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  mask;
        logic [DW-1:0]     wdata;
    } ctl_t;

    ctl_t             c_d, c_q;
    logic             p_start, c_start, start, selected, wr_req;
    logic [LANES-1:0] lane_mask;
    logic [HI_W-1:0]  hi_use;

    always_comb begin
        p_start   = !as_proc_n && !csa_n;
        c_start   = !as_ctrl_n && !p_start;
        start     = (p_start || c_start) && !sleep;
        selected  = !csa_n && csb && !csc_n;
        wr_req    = !wr_all_n || !wr_lane_en_n;
        lane_mask = !wr_all_n ? {LANES{1'b1}} : (!wr_lane_en_n ? ~lane_n : '0);

        seq_load_o = start;
        seq_step_o = !start && !sleep && c_q.act && adv_i;

        c_d       = c_q;
        c_d.wdata = wdata;
        c_d.op    = OP_IDLE;
        c_d.mask  = '0;
        hi_use    = c_q.hi;

        if (sleep) begin
            c_d.act = 1'b0;
        end else if (start) begin
            c_d.act = selected;
            c_d.hi  = addr_hi_i;
            hi_use  = addr_hi_i;
            if (selected) begin
                c_d.op = (c_start && wr_req) ? OP_WRITE : OP_READ;
            end
        end else if (c_q.act) begin
            c_d.op = wr_req ? OP_WRITE : OP_READ;
        end

        c_d.addr = {hi_use, seq_bits_i};
        if (c_d.op == OP_WRITE) c_d.mask = lane_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign st_op_o    = c_q.op;
    assign st_addr_o  = c_q.addr;
    assign st_mask_o  = c_q.mask;
    assign st_wdata_o = c_q.wdata;

endmodule

// File: rtl/sburst_array.sv
module sburst_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    wr_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANES-1:0]        mask_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output logic [LANES*LANE_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [LANE_W-1:0] mem [DEPTH];

            always_ff @(posedge clk) begin
                if (wr_i && mask_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
            end

            assign rdata_o[g*LANE_W +: LANE_W] = mem[addr_i];
        end
    endgenerate

endmodule

// File: rtl/sburst_sram.sv
module sburst_sram
    import sburst_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int LANES        = 4,
    parameter int LANE_W       = 8,
    parameter int BURST_W      = 2,
    parameter bit BURST_LINEAR = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    csa_n,
    input  logic                    csb,
    input  logic                    csc_n,
    input  logic                    as_proc_n,
    input  logic                    as_ctrl_n,
    input  logic                    adv_i,
    input  logic                    wr_all_n,
    input  logic                    wr_lane_en_n,
    input  logic [LANES-1:0]        lane_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    out_en_n,
    input  logic                    sleep,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);

    localparam int DW = LANES * LANE_W;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
    } out_t;

    logic               seq_load, seq_step;
    logic [BURST_W-1:0] seq_bits;
    sb_op_e             st_op;
    logic [ADDR_W-1:0]  st_addr;
    logic [LANES-1:0]   st_mask;
    logic [DW-1:0]      st_wdata;
    logic [DW-1:0]      mem_rd;
    out_t               o_d, o_q;

    sburst_seq #(
        .BURST_W      (BURST_W),
        .BURST_LINEAR (BURST_LINEAR)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (seq_load),
        .step_i    (seq_step),
        .ld_bits_i (addr[BURST_W-1:0]),
        .bits_o    (seq_bits)
    );

    sburst_ctl #(
        .ADDR_W  (ADDR_W),
        .BURST_W (BURST_W),
        .LANES   (LANES),
        .DW      (DW)
    ) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .csa_n        (csa_n),
        .csb          (csb),
        .csc_n        (csc_n),
        .as_proc_n    (as_proc_n),
        .as_ctrl_n    (as_ctrl_n),
        .adv_i        (adv_i),
        .wr_all_n     (wr_all_n),
        .wr_lane_en_n (wr_lane_en_n),
        .lane_n       (lane_n),
        .addr_hi_i    (addr[ADDR_W-1:BURST_W]),
        .wdata        (wdata),
        .sleep        (sleep),
        .seq_bits_i   (seq_bits),
        .seq_load_o   (seq_load),
        .seq_step_o   (seq_step),
        .st_op_o      (st_op),
        .st_addr_o    (st_addr),
        .st_mask_o    (st_mask),
        .st_wdata_o   (st_wdata)
    );

    sburst_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk     (clk),
        .wr_i    (st_op == OP_WRITE),
        .addr_i  (st_addr),
        .mask_i  (st_mask),
        .wdata_i (st_wdata),
        .rdata_o (mem_rd)
    );

    always_comb begin
        o_d     = o_q;
        o_d.vld = 1'b0;
        if (!sleep && st_op == OP_READ) begin
            o_d.vld  = 1'b1;
            o_d.data = mem_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign rdata  = out_en_n ? '0 : o_q.data;
    assign rvalid = !out_en_n && o_q.vld;

endmodule

// File: rtl/sburst_sram_chk.sv
module sburst_sram_chk (
    input logic clk,
    input logic rst_n,
    input logic csa_n,
    input logic csb,
    input logic csc_n,
    input logic as_proc_n,
    input logic as_ctrl_n,
    input logic wr_all_n,
    input logic wr_lane_en_n,
    input logic out_en_n,
    input logic sleep,
    input logic rvalid
);

    logic sel_w, pst_w, cst_w, wr_w;
    assign sel_w = !csa_n && csb && !csc_n;
    assign pst_w = !as_proc_n && !csa_n;
    assign cst_w = !as_ctrl_n && !pst_w;
    assign wr_w  = !wr_all_n || !wr_lane_en_n;

    // R2
    read_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pst_w && sel_w && !sleep) |=> ##1 (out_en_n || rvalid || $past(sleep)));

    // R5
    write_no_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cst_w && sel_w && wr_w && !sleep) |=> ##1 !rvalid);

    // R6
    deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pst_w || cst_w) && !sel_w && !sleep) |=> ##1 !rvalid);

    // R8
    sleep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !rvalid);

endmodule

bind sburst_sram sburst_sram_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .csa_n        (csa_n),
    .csb          (csb),
    .csc_n        (csc_n),
    .as_proc_n    (as_proc_n),
    .as_ctrl_n    (as_ctrl_n),
    .wr_all_n     (wr_all_n),
    .wr_lane_en_n (wr_lane_en_n),
    .out_en_n     (out_en_n),
    .sleep        (sleep),
    .rvalid       (rvalid)
);

// File: tb/sburst_sram_tb.sv
module sburst_sram_tb;

    localparam int  AW  = 4;
    localparam int  N   = 1 << AW;
    localparam bit  LIN = 1'b0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csa_n, csb, csc_n, as_proc_n, as_ctrl_n, adv_i;
    logic        wr_all_n, wr_lane_en_n, out_en_n, sleep;
    logic [3:0]  lane_n;
    logic [AW-1:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        rvalid;

    logic [31:0] exp_mem [N];
    int nvec = 0;
    int nerr = 0;
    logic [31:0] hold;

    always #5 clk = ~clk;

    sburst_sram #(.ADDR_W(AW), .BURST_LINEAR(LIN)) u_dut (
        .clk(clk), .rst_n(rst_n), .csa_n(csa_n), .csb(csb), .csc_n(csc_n),
        .as_proc_n(as_proc_n), .as_ctrl_n(as_ctrl_n), .adv_i(adv_i),
        .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n), .lane_n(lane_n),
        .addr(addr), .wdata(wdata), .out_en_n(out_en_n), .sleep(sleep),
        .rdata(rdata), .rvalid(rvalid)
    );

    task automatic idle_in();
        as_proc_n = 1; as_ctrl_n = 1; adv_i = 0; wr_all_n = 1; wr_lane_en_n = 1;
        lane_n = 4'hF; csa_n = 0; csb = 1; csc_n = 0; out_en_n = 0; sleep = 0;
        addr = '0; wdata = 32'hDEAD_BEEF;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic desel();
        idle_in(); as_ctrl_n = 0; csb = 0; step();
        idle_in(); step();
    endtask

    task automatic read_all(input string r);
        for (int a = 0; a < N; a++) begin
            idle_in(); as_proc_n = 0; addr = a[AW-1:0]; step();
            if (a > 0) begin
                chk({r, " rvalid"}, {31'd0, rvalid}, 32'd1);
                chk({r, " rdata"}, rdata, exp_mem[a-1]);
            end
        end
        idle_in(); step();
        chk({r, " rdata"}, rdata, exp_mem[N-1]);
        desel();
    endtask

    function automatic logic [1:0] bseq(input logic [1:0] base, input logic [1:0] n);
        return LIN ? base + n : base ^ n;
    endfunction

    initial begin
        #(200000 * 10);
        nerr++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        idle_in();
        step(); step();
        rst_n = 1; step();
        // reset state
        chk("reset rvalid", {31'd0, rvalid}, 32'd0);
        chk("reset rdata", rdata, 32'd0);

        // R3: global writes, byte controls scrambled; R5 write leaves rvalid low
        for (int a = 0; a < N; a++) begin
            idle_in(); as_ctrl_n = 0; addr = a[AW-1:0]; wr_all_n = 0;
            wr_lane_en_n = a[0]; lane_n = a[3:0];
            wdata = 32'hC3A5_0F00 ^ (a * 32'h1111_1111);
            exp_mem[a] = wdata;
            step();
            if (a > 0) chk("R5 write rvalid", {31'd0, rvalid}, 32'd0);
        end
        idle_in(); step();
        desel();
        read_all("R3");

        // R4: every lane mask once
        for (int a = 0; a < N; a++) begin
            idle_in(); as_ctrl_n = 0; addr = a[AW-1:0]; wr_lane_en_n = 0;
            lane_n = a[3:0];
            wdata = 32'h5A5A_5A5A + a * 32'h0102_0408;
            for (int l = 0; l < 4; l++)
                if (!lane_n[l]) exp_mem[a][l*8 +: 8] = wdata[l*8 +: 8];
            step();
        end
        idle_in(); step();
        desel();
        read_all("R4");

        // R5: write then immediate read of the same address
        hold = rdata;
        idle_in(); as_ctrl_n = 0; addr = 9; wr_all_n = 0; wdata = 32'h0BAD_F00D;
        exp_mem[9] = wdata; step();
        idle_in(); as_proc_n = 0; addr = 9; step();
        chk("R5 rvalid after write", {31'd0, rvalid}, 32'd0);
        chk("R5 rdata held", rdata, hold);
        idle_in(); step();
        chk("R5 read-after-write", rdata, 32'h0BAD_F00D);
        desel();

        // R1: every chip-enable combination, read start
        for (int c = 0; c < 8; c++) begin
            idle_in(); csa_n = c[2]; csb = c[1]; csc_n = c[0]; as_ctrl_n = 0; addr = 3;
            step();
            idle_in(); step();
            chk("R1 select read", {31'd0, rvalid}, {31'd0, c == 2});
            desel();
        end
        // R1: write attempts with every deselecting combination
        for (int c = 0; c < 8; c++) begin
            if (c != 2) begin
                idle_in(); csa_n = c[2]; csb = c[1]; csc_n = c[0]; as_ctrl_n = 0;
                addr = 2; wr_all_n = 0; wdata = 32'hFFFF_0000 + c;
                step(); idle_in(); step();
            end
        end
        idle_in(); as_proc_n = 0; addr = 2; step(); idle_in(); step();
        chk("R1 deselected writes ignored", rdata, exp_mem[2]);

        // R6: read in flight survives the deselecting edge
        idle_in(); as_proc_n = 0; addr = 11; step();
        idle_in(); as_ctrl_n = 0; csb = 0; step();
        chk("R6 in-flight read", rdata, exp_mem[11]);
        idle_in(); step();
        chk("R6 idle after one cycle", {31'd0, rvalid}, 32'd0);

        // R9: both strobes with writes asserted -> processor read wins
        idle_in(); as_proc_n = 0; as_ctrl_n = 0; addr = 5; wr_all_n = 0;
        wdata = 32'h1234_5678; step();
        idle_in(); step();
        chk("R9 both strobes reads", rdata, exp_mem[5]);
        chk("R9 both strobes rvalid", {31'd0, rvalid}, 32'd1);
        desel();
        idle_in(); as_proc_n = 0; addr = 5; step(); idle_in(); step();
        chk("R9 no write on processor start", rdata, exp_mem[5]);
        desel();
        idle_in(); csa_n = 1; as_proc_n = 0; addr = 5; step();
        idle_in(); step();
        chk("R9 processor strobe gated by csa_n", {31'd0, rvalid}, 32'd0);

        // R10: burst walk with advance and hold
        begin
            logic [1:0] pat [6] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd3, 2'd0};
            logic       av  [6] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
            for (int i = 0; i < 6; i++) begin
                idle_in(); adv_i = av[i];
                if (i == 0) begin as_ctrl_n = 0; addr = 6; end
                else addr = 4'hD;
                step();
                if (i > 0) chk("R10 burst beat", rdata, exp_mem[{2'b01, bseq(2'd2, pat[i-1])}]);
            end
            idle_in(); step();
            chk("R10 burst beat", rdata, exp_mem[{2'b01, bseq(2'd2, pat[5])}]);
            desel();
        end

        // R11: advance and write with no burst active
        idle_in(); adv_i = 1; wr_all_n = 0; addr = 1; wdata = 32'h7777_7777; step();
        step();
        chk("R11 idle rvalid", {31'd0, rvalid}, 32'd0);
        idle_in(); as_proc_n = 0; addr = 1; step(); idle_in(); step();
        chk("R11 no write", rdata, exp_mem[1]);
        desel();

        // R8: sleep collides with a pipelined read and a controller write
        idle_in(); as_proc_n = 0; addr = 7; step();
        idle_in(); sleep = 1; as_ctrl_n = 0; wr_all_n = 0; addr = 0;
        wdata = 32'h9999_9999; step();
        chk("R8 sleep clears output", {31'd0, rvalid}, 32'd0);
        step();
        chk("R8 sleep holds idle", {31'd0, rvalid}, 32'd0);
        idle_in(); adv_i = 1; step();
        chk("R8 first awake edge", {31'd0, rvalid}, 32'd0);
        step();
        chk("R8 burst ended", {31'd0, rvalid}, 32'd0);
        idle_in(); as_proc_n = 0; addr = 0; step();
        chk("R8 read not yet out", {31'd0, rvalid}, 32'd0);
        idle_in(); step();
        chk("R8 contents kept", rdata, exp_mem[0]);

        // R7: asynchronous output enable while output valid
        out_en_n = 1; #1;
        chk("R7 rdata forced", rdata, 32'd0);
        chk("R7 rvalid forced", {31'd0, rvalid}, 32'd0);
        out_en_n = 0; #1;
        chk("R7 restored", rdata, exp_mem[0]);
        desel();

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule